// File: doc/BRIEF.md
# Parallel Host Mailbox Port

This block connects an external host processor to an internal modem controller over a byte-wide parallel bus. The host sees two locations, selected by a single address line. The first is a data register that carries payload bytes and text commands in both directions. The second is an 8-bit status word. It combines the hardware handshake flags and their interrupt enables with the modem-control and break bits that software owns. An access counts only when the chip select and the serial/parallel mode select are both low.

The host strobes are asynchronous to the block. All host control lines and the data bus are passed through a parameterised synchroniser. A register access then takes effect on the synchronised rising edge of its strobe, so one strobe can never produce two accesses. The internal side has single-cycle load and take strobes for the two data directions. It also has set and clear strobes for carrier detect and receive break, and it sees terminal ready and send break as levels. The active-low host interrupt follows the handshake flags and their enables.

Top module: `host_mailbox_port`

## Requirements
- R1: After reset the status word reads 0x21 (only carrier detect and transmit-empty set), the host interrupt is high, terminal ready, send break and the overrun flag are 0, and tx_avail is 0.
- R2: A strobe counts only while host_cs_n and host_ser_sel are both low. host_a0 = 0 selects the data register and host_a0 = 1 selects the status word. A strobe with either select high changes nothing.
- R3: The status word layout is bit 7 receive interrupt enable, bit 6 transmit interrupt enable, bit 5 carrier detect, bit 4 receive break, bit 3 terminal ready, bit 2 send break, bit 1 receive-full, bit 0 transmit-empty.
- R4: A host write to the status word updates only bits 7, 6, 3 and 2. Bits 5, 4, 1 and 0 keep their values.
- R5: A host write to the data register places the byte on tx_byte and clears transmit-empty. A tx_take pulse sets transmit-empty again, and tx_avail is the inverse of transmit-empty.
- R6: An rx_load pulse stores rx_byte and sets receive-full. A host data read returns that byte, and completing the read clears receive-full.
- R7: A host access takes effect at the (SYNC_STAGES+1)-th rising clock edge after its strobe returns high. It has no effect while the strobe is held low, and each strobe makes exactly one access.
- R8: host_irq_n is low exactly when (receive-full and bit 7) or (transmit-empty and bit 6) hold. With IRQ_REGISTERED = 0 it follows the flags in the same cycle.
- R9: Carrier detect and receive break are set and cleared only by the internal strobes, with set taking priority over clear. ctl_dtr and ctl_sbrk show status bits 3 and 2.
- R10: An rx_load while receive-full is set overwrites the byte and sets rx_overrun, unless a host data read completes in the same cycle. rx_overrun is sticky until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Register select: 0 data, 1 status |
| host_ser_sel | input | 1 | Serial/parallel mode select, low for parallel access |
| host_din | input | DATA_W | Host write data |
| host_dout | output | DATA_W | Host read data, selected by host_a0 |
| host_irq_n | output | 1 | Host interrupt, active low |
| rx_load | input | 1 | Internal pulse: load a byte for the host |
| rx_byte | input | DATA_W | Byte loaded by rx_load |
| tx_take | input | 1 | Internal pulse: host byte consumed |
| tx_byte | output | DATA_W | Last byte written by the host |
| dcd_set | input | 1 | Set carrier detect |
| dcd_clr | input | 1 | Clear carrier detect |
| rbrk_set | input | 1 | Set receive break |
| rbrk_clr | input | 1 | Clear receive break |
| ctl_dtr | output | 1 | Terminal ready bit from the host |
| ctl_sbrk | output | 1 | Send break bit from the host |
| rx_full | output | 1 | Receive-full flag |
| tx_avail | output | 1 | Host byte waiting (not transmit-empty) |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
The internal strobes act on the next rising edge. The bench therefore samples flags, tx_byte and the interrupt at the falling edge after the pulse. A host access lands SYNC_STAGES+1 rising edges after its strobe is released, and every access task waits exactly that many edges before it samples. The latency test looks at ctl_dtr half a cycle after the SYNC_STAGES-th edge, where the bit must still be old, and again after the next edge, where it must be new. A strobe held low for many cycles is checked through the interrupt pin. The pin must not move until release and must move once afterwards.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
   // status word bit positions (the host decodes these)
   localparam int unsigned ST_RIE  = 7;
   localparam int unsigned ST_TIE  = 6;
   localparam int unsigned ST_DCD  = 5;
   localparam int unsigned ST_RBRK = 4;
   localparam int unsigned ST_DTR  = 3;
   localparam int unsigned ST_SBRK = 2;
   localparam int unsigned ST_RXF  = 1;
   localparam int unsigned ST_TXE  = 0;
   localparam int unsigned ST_W    = 8;
   localparam logic [ST_W-1:0] ST_RESET = 8'h21;

   typedef struct packed {
      logic rd_data;
      logic wr_data;
      logic wr_stat;
   } hmb_evt_t;
endpackage

// File: rtl/hmb_sync.sv
module hmb_sync #(
   parameter int unsigned           W       = 8,
   parameter int unsigned           STAGES  = 2,
   parameter logic [W-1:0]          RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hmb_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hmb_strobe_decode.sv
module hmb_strobe_decode
   import hmb_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              a0,
   input  logic              ser_sel,
   input  logic [DATA_W-1:0] din,
   output hmb_evt_t          evt,
   output logic [DATA_W-1:0] wdata
);
   localparam int unsigned BW    = DATA_W + 5;
   localparam int unsigned I_CS  = DATA_W + 4;
   localparam int unsigned I_RD  = DATA_W + 3;
   localparam int unsigned I_WR  = DATA_W + 2;
   localparam int unsigned I_A0  = DATA_W + 1;
   localparam int unsigned I_SER = DATA_W;
   localparam logic [BW-1:0] IDLE = {3'b111, 1'b0, 1'b1, {DATA_W{1'b0}}};

   logic [BW-1:0] s_now;
   logic [BW-1:0] s_prev;

   hmb_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, rd_n, wr_n, a0, ser_sel, din}),
      .q     (s_now)
   );

   // one more stage: holds the bus as seen while the strobe was still low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_prev <= IDLE;
      else        s_prev <= s_now;
   end

   logic sel_ok, rd_rise, wr_rise;
   always_comb begin
      sel_ok  = !s_prev[I_CS] && !s_prev[I_SER];
      rd_rise = !s_prev[I_RD] && s_now[I_RD];
      wr_rise = !s_prev[I_WR] && s_now[I_WR];
      evt.rd_data = sel_ok && rd_rise && !s_prev[I_A0];
      evt.wr_data = sel_ok && wr_rise && !s_prev[I_A0];
      evt.wr_stat = sel_ok && wr_rise &&  s_prev[I_A0];
      wdata       = s_prev[DATA_W-1:0];
   end

   assert_one_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt.rd_data |=> !evt.rd_data);
   assert_one_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.wr_data || evt.wr_stat) |=> !(evt.wr_data || evt.wr_stat));
endmodule

// File: rtl/hmb_regs.sv
module hmb_regs
   import hmb_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  hmb_evt_t          evt,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rx_load,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              tx_take,
   input  logic              dcd_set,
   input  logic              dcd_clr,
   input  logic              rbrk_set,
   input  logic              rbrk_clr,
   output logic [ST_W-1:0]   status,
   output logic [DATA_W-1:0] rx_data,
   output logic [DATA_W-1:0] tx_data,
   output logic              overrun
);
   logic [ST_W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_RESET;
         rx_data <= '0;
         tx_data <= '0;
         overrun <= 1'b0;
      end else begin
         // host-owned bits
         if (evt.wr_stat) begin
            st[ST_RIE]  <= wdata[ST_RIE];
            st[ST_TIE]  <= wdata[ST_TIE];
            st[ST_DTR]  <= wdata[ST_DTR];
            st[ST_SBRK] <= wdata[ST_SBRK];
         end
         // controller-owned bits
         if (dcd_set)       st[ST_DCD] <= 1'b1;
         else if (dcd_clr)  st[ST_DCD] <= 1'b0;
         if (rbrk_set)      st[ST_RBRK] <= 1'b1;
         else if (rbrk_clr) st[ST_RBRK] <= 1'b0;
         // receive direction
         if (rx_load) begin
            rx_data   <= rx_byte;
            st[ST_RXF] <= 1'b1;
            if (st[ST_RXF] && !evt.rd_data) overrun <= 1'b1;
         end else if (evt.rd_data) begin
            st[ST_RXF] <= 1'b0;
         end
         // transmit direction
         if (evt.wr_data) begin
            tx_data    <= wdata;
            st[ST_TXE] <= 1'b0;
         end else if (tx_take) begin
            st[ST_TXE] <= 1'b1;
         end
      end
   end

   assign status = st;

   assert_rxf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st[ST_RXF]) |-> $past(rx_load));
   assert_rxf_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st[ST_RXF]) |-> $past(evt.rd_data));
   assert_txe_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st[ST_TXE]) |-> $past(tx_take));
   assert_txe_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st[ST_TXE]) |-> $past(evt.wr_data));
   assert_hw_flags_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.wr_stat && !rx_load && !tx_take && !dcd_set && !dcd_clr && !rbrk_set && !rbrk_clr)
      |=> (st[ST_TXE] == $past(st[ST_TXE])) && (st[ST_RXF] == $past(st[ST_RXF]))
          && (st[ST_DCD] == $past(st[ST_DCD])) && (st[ST_RBRK] == $past(st[ST_RBRK])));
   assert_dcd_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!dcd_set && !dcd_clr) |=> $stable(st[ST_DCD]));
   assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
   assert_ovr_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(rx_load && st[ST_RXF]));
endmodule

// File: rtl/hmb_irq.sv
module hmb_irq #(
   parameter bit REGISTERED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_ie,
   input  logic tx_ie,
   input  logic rx_full,
   input  logic tx_empty,
   output logic irq_n
);
   logic req;
   assign req = (rx_ie && rx_full) || (tx_ie && tx_empty);

   if (REGISTERED) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b1;
         else        irq_q <= !req;
      end
      assign irq_n = irq_q;
      assert_irq_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(irq_n) |-> $past(rx_full || tx_empty));
   end else begin : g_comb
      assign irq_n = !req;
      assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !irq_n |-> (rx_full || tx_empty));
   end
endmodule

// File: rtl/host_mailbox_port.sv
module host_mailbox_port
   import hmb_pkg::*;
#(
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs_n,
   input  logic              host_rd_n,
   input  logic              host_wr_n,
   input  logic              host_a0,
   input  logic              host_ser_sel,
   input  logic [DATA_W-1:0] host_din,
   output logic [DATA_W-1:0] host_dout,
   output logic              host_irq_n,
   input  logic              rx_load,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              tx_take,
   output logic [DATA_W-1:0] tx_byte,
   input  logic              dcd_set,
   input  logic              dcd_clr,
   input  logic              rbrk_set,
   input  logic              rbrk_clr,
   output logic              ctl_dtr,
   output logic              ctl_sbrk,
   output logic              rx_full,
   output logic              tx_avail,
   output logic              rx_overrun
);
   if (DATA_W < ST_W) begin : g_bad_width
      $error("host_mailbox_port: DATA_W must be at least 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("host_mailbox_port: SYNC_STAGES must be at least 2");
   end

   localparam int unsigned PAD_W = DATA_W - ST_W;

   hmb_evt_t          evt;
   logic [DATA_W-1:0] wdata;
   logic [ST_W-1:0]   status;
   logic [DATA_W-1:0] rx_data;

   hmb_strobe_decode #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (host_cs_n),
      .rd_n    (host_rd_n),
      .wr_n    (host_wr_n),
      .a0      (host_a0),
      .ser_sel (host_ser_sel),
      .din     (host_din),
      .evt     (evt),
      .wdata   (wdata)
   );

   hmb_regs #(.DATA_W(DATA_W)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .wdata    (wdata),
      .rx_load  (rx_load),
      .rx_byte  (rx_byte),
      .tx_take  (tx_take),
      .dcd_set  (dcd_set),
      .dcd_clr  (dcd_clr),
      .rbrk_set (rbrk_set),
      .rbrk_clr (rbrk_clr),
      .status   (status),
      .rx_data  (rx_data),
      .tx_data  (tx_byte),
      .overrun  (rx_overrun)
   );

   hmb_irq #(.REGISTERED(IRQ_REGISTERED)) i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_ie    (status[ST_RIE]),
      .tx_ie    (status[ST_TIE]),
      .rx_full  (status[ST_RXF]),
      .tx_empty (status[ST_TXE]),
      .irq_n    (host_irq_n)
   );

   logic [DATA_W-1:0] status_wide;
   if (PAD_W > 0) begin : g_pad
      assign status_wide = {{PAD_W{1'b0}}, status};
   end else begin : g_nopad
      assign status_wide = status;
   end

   assign host_dout = host_a0 ? status_wide : rx_data;
   assign ctl_dtr   = status[ST_DTR];
   assign ctl_sbrk  = status[ST_SBRK];
   assign rx_full   = status[ST_RXF];
   assign tx_avail  = !status[ST_TXE];

   assert_host_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cs_n && host_rd_n && host_wr_n && !rx_load && !tx_take
       && $past(host_cs_n && host_rd_n && host_wr_n, SYNC_STAGES + 1))
      |=> $stable(status[ST_DTR]));
endmodule

// File: tb/test_host_mailbox_port.sv
module test_host_mailbox_port;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
   logic       host_a0 = 1'b0, host_ser_sel = 1'b0;
   logic [7:0] host_din = '0, host_dout, rx_byte = '0, tx_byte;
   logic       host_irq_n, rx_load = 1'b0, tx_take = 1'b0;
   logic       dcd_set = 1'b0, dcd_clr = 1'b0, rbrk_set = 1'b0, rbrk_clr = 1'b0;
   logic       ctl_dtr, ctl_sbrk, rx_full, tx_avail, rx_overrun;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   host_mailbox_port #(.DATA_W(8), .SYNC_STAGES(SYNC), .IRQ_REGISTERED(1'b0)) i_host_mailbox_port (
      .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
      .host_wr_n(host_wr_n), .host_a0(host_a0), .host_ser_sel(host_ser_sel),
      .host_din(host_din), .host_dout(host_dout), .host_irq_n(host_irq_n),
      .rx_load(rx_load), .rx_byte(rx_byte), .tx_take(tx_take), .tx_byte(tx_byte),
      .dcd_set(dcd_set), .dcd_clr(dcd_clr), .rbrk_set(rbrk_set), .rbrk_clr(rbrk_clr),
      .ctl_dtr(ctl_dtr), .ctl_sbrk(ctl_sbrk), .rx_full(rx_full), .tx_avail(tx_avail),
      .rx_overrun(rx_overrun)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // one host strobe; returns bus value seen while the strobe was low
   task automatic host_raw(input bit wr, input bit a0, input logic [7:0] wd,
                           input bit cs_n_v, input bit ser_v, input int hold,
                           output logic [7:0] rd);
      @(negedge clk);
      host_cs_n = cs_n_v; host_ser_sel = ser_v; host_a0 = a0; host_din = wd;
      if (wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
      repeat (hold) @(negedge clk);
      rd = host_dout;
      host_wr_n = 1'b1; host_rd_n = 1'b1; host_cs_n = 1'b1; host_ser_sel = 1'b0;
      repeat (SYNC + 1) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic host_wr(input bit a0, input logic [7:0] wd);
      logic [7:0] unused_rd;
      host_raw(1'b1, a0, wd, 1'b0, 1'b0, 3, unused_rd);
   endtask

   task automatic host_rd(input bit a0, output logic [7:0] v);
      host_raw(1'b0, a0, 8'h00, 1'b0, 1'b0, 3, v);
   endtask

   task automatic pulse_rx(input logic [7:0] b);
      @(negedge clk); rx_load = 1'b1; rx_byte = b;
      @(negedge clk); rx_load = 1'b0;
   endtask

   task automatic pulse_take();
      @(negedge clk); tx_take = 1'b1;
      @(negedge clk); tx_take = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R1 irq_n", host_irq_n, 1);
      check("R1 dtr", ctl_dtr, 0);
      check("R1 sbrk", ctl_sbrk, 0);
      check("R1 overrun", rx_overrun, 0);
      check("R1 tx_avail", tx_avail, 0);
      host_rd(1'b1, v);
      check("R1 R3 status", v, 8'h21);
   endtask

   task automatic t_ignore();
      logic [7:0] v;
      host_raw(1'b1, 1'b0, 8'h5A, 1'b1, 1'b0, 3, v);
      check("R2 cs high data write", tx_byte, 8'h00);
      host_raw(1'b1, 1'b0, 8'h5A, 1'b0, 1'b1, 3, v);
      check("R2 serial mode data write", tx_byte, 8'h00);
      host_raw(1'b1, 1'b1, 8'hFF, 1'b1, 1'b0, 3, v);
      check("R2 cs high status write dtr", ctl_dtr, 0);
      host_rd(1'b1, v);
      check("R2 status untouched", v, 8'h21);
   endtask

   task automatic t_latency();
      logic [7:0] v;
      @(negedge clk);
      host_cs_n = 1'b0; host_a0 = 1'b1; host_din = 8'h08; host_wr_n = 1'b0;
      repeat (6) @(negedge clk);
      check("R7 no effect while low", ctl_dtr, 0);
      host_wr_n = 1'b1; host_cs_n = 1'b1;
      repeat (SYNC) @(posedge clk);
      #2 check("R7 not yet at edge SYNC", ctl_dtr, 0);
      @(posedge clk);
      #2 check("R7 due at edge SYNC+1", ctl_dtr, 1);
      @(negedge clk);
      host_rd(1'b1, v);
      check("R3 dtr at bit 3", v, 8'h29);
      host_wr(1'b1, 8'h00);
   endtask

   task automatic t_status_write();
      logic [7:0] v;
      host_wr(1'b1, 8'hFF);
      host_rd(1'b1, v);
      check("R4 only host bits change", v, 8'hED);
      check("R9 sbrk out", ctl_sbrk, 1);
      check("R8 tx irq", host_irq_n, 0);
      host_wr(1'b1, 8'h00);
      host_rd(1'b1, v);
      check("R4 host bits cleared", v, 8'h21);
      check("R8 irq released", host_irq_n, 1);
   endtask

   task automatic t_tx();
      logic [7:0] v;
      host_wr(1'b0, 8'hA5);
      check("R5 tx_byte", tx_byte, 8'hA5);
      check("R5 tx_avail", tx_avail, 1);
      host_rd(1'b1, v);
      check("R5 txe cleared", v, 8'h20);
      pulse_take();
      check("R5 txe set by take", tx_avail, 0);
      pulse_take();
      check("R5 take when empty", tx_avail, 0);
   endtask

   task automatic t_rx();
      logic [7:0] v;
      pulse_rx(8'h3C);
      check("R6 rx_full", rx_full, 1);
      host_rd(1'b1, v);
      check("R6 R3 rxf at bit 1", v, 8'h23);
      host_rd(1'b0, v);
      check("R6 data read", v, 8'h3C);
      check("R6 rxf cleared", rx_full, 0);
      check("R10 no overrun", rx_overrun, 0);
   endtask

   task automatic t_irq();
      logic [7:0] v;
      host_wr(1'b1, 8'h80);
      check("R8 rie alone", host_irq_n, 1);
      pulse_rx(8'h77);
      check("R8 rx irq same cycle", host_irq_n, 0);
      host_rd(1'b0, v);
      check("R8 rx irq cleared", host_irq_n, 1);
      host_wr(1'b1, 8'h40);
      check("R8 tie with empty", host_irq_n, 0);
      host_raw(1'b1, 1'b0, 8'h99, 1'b0, 1'b0, 12, v);
      check("R7 long strobe one write", tx_byte, 8'h99);
      check("R8 irq after write", host_irq_n, 1);
      pulse_take();
      check("R8 irq after take", host_irq_n, 0);
      host_wr(1'b1, 8'h00);
   endtask

   task automatic t_modem();
      logic [7:0] v;
      @(negedge clk); dcd_clr = 1'b1; rbrk_set = 1'b1;
      @(negedge clk); dcd_clr = 1'b0; rbrk_set = 1'b0;
      host_wr(1'b1, 8'h00);
      host_rd(1'b1, v);
      check("R9 R4 dcd clr rbrk set kept", v, 8'h11);
      @(negedge clk); dcd_set = 1'b1; dcd_clr = 1'b1; rbrk_clr = 1'b1;
      @(negedge clk); dcd_set = 1'b0; dcd_clr = 1'b0; rbrk_clr = 1'b0;
      host_rd(1'b1, v);
      check("R9 set wins, rbrk cleared", v, 8'h21);
   endtask

   task automatic t_overrun();
      logic [7:0] v;
      pulse_rx(8'h11);
      check("R10 first load", rx_overrun, 0);
      pulse_rx(8'h22);
      check("R10 overrun set", rx_overrun, 1);
      host_rd(1'b0, v);
      check("R10 newest byte kept", v, 8'h22);
      check("R10 sticky", rx_overrun, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ignore();
      t_latency();
      t_status_write();
      t_tx();
      t_rx();
      t_irq();
      t_modem();
      t_overrun();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule